// File: doc/BRIEF.md
# Trace Record Formatter

This block converts a captured transaction-layer packet header into a fixed-length trace record and streams it out one 32-bit word per handshake. It sits between the capture logic, which already picked the packets worth tracing, and the path that writes records to memory. Each record carries a timestamp taken from a free-running counter inside the block. The stamp is the counter value on the clock edge that accepts the capture.

Two record layouts are offered. The compact layout is four words long. Its first word squeezes the header's format, type, tag-extension, hint and ordering bits and its length field together with the low eleven timestamp bits. The full layout is eight words long. It opens with an all-ones marker word, then carries the optional PASID prefix, the whole header, a zero pad word and the full 32-bit timestamp. The block holds one record at a time. A capture that arrives while a record is still being emitted is discarded and counted.

Top module: `trace_rec_fmt`

## Requirements
- R1: After reset `rec_valid` is 0 and `drop_cnt` is 0, and the timestamp counter restarts from 0.
- R2: With `fmt_sel` = 0 (compact), word 0 is {hdr_dw0[30:29], hdr_dw0[28:24], hdr_dw0[23], hdr_dw0[19], hdr_dw0[16], hdr_dw0[13], hdr_dw0[9:0], stamp[10:0]}, packed from bit 31 down to bit 0.
- R3: With `fmt_sel` = 0, the record is exactly four words, and words 1, 2 and 3 equal `hdr_dw1`, `hdr_dw2` and `hdr_dw3` unchanged.
- R4: With `fmt_sel` = 1 (full), the record is exactly eight words: marker, prefix, hdr_dw0, hdr_dw1, hdr_dw2, hdr_dw3, 32'h0, stamp. `rec_last` is 1 only on the final word of a record.
- R5: The full record's first word is 32'hFFFFFFFF, which is 21 ones in bits 31:11 followed by 11 ones in bits 10:0.
- R6: The full record's second word equals `pfx_word` when `pfx_present` is 1, and is 32'h0 when `pfx_present` is 0.
- R7: The timestamp counter increments by one each clock after reset. A record carries the counter value of the edge that accepted its capture: all 32 bits in the full layout, bits 10:0 in the compact layout.
- R8: While `rec_valid` is 1 and `rec_ready` is 0, `rec_data` and `rec_last` hold their values.
- R9: A capture strobe seen while a record is held is ignored and leaves the held record unchanged. It raises `drop_cnt` by one, and the counter saturates at all ones. Without a strobe `drop_cnt` is unchanged.
- R10: A capture strobe on the same cycle that the final word is handed off is refused and counted as a drop. `rec_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Capture strobe for the header on the inputs |
| hdr_dw0 | input | 32 | Header dword 0 |
| hdr_dw1 | input | 32 | Header dword 1 |
| hdr_dw2 | input | 32 | Header dword 2 |
| hdr_dw3 | input | 32 | Header dword 3 |
| pfx_word | input | 32 | PASID prefix dword |
| pfx_present | input | 1 | The prefix dword is valid |
| fmt_sel | input | 1 | 0 selects the compact record, 1 selects the full record |
| rec_data | output | 32 | Current record word |
| rec_valid | output | 1 | A record word is presented |
| rec_ready | input | 1 | The consumer takes the word |
| rec_last | output | 1 | Current word is the final word of the record |
| drop_cnt | output | DROP_W | Saturating count of refused captures |

## Verification
The bench holds the capture strobe high through whole records so that it hits the cycle the last word is handed off. A design that freed its slot one cycle early would accept that capture and miss the drop. Header inputs change every cycle, so a design that read the header late, or let a refused capture overwrite the held record, would emit the wrong words. Random back-pressure tests whether words hold steady while stalled, and a long stall drives the drop counter into saturation, where a counter that wrapped would show up as 0. Timestamps are compared bit for bit, so stamping one edge early or late shows up at once.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int WORD_W  = 32;
    localparam int MAX_WRD = 8;
    localparam int IDX_W   = $clog2(MAX_WRD);

    localparam logic [WORD_W-1:0] FULL_MARK = {21'h1FFFFF, 11'h7FF};

    typedef enum logic {
        LAYOUT_COMPACT = 1'b0,
        LAYOUT_FULL    = 1'b1
    } layout_e;

    typedef logic [MAX_WRD-1:0][WORD_W-1:0] rec_words_t;

    typedef struct packed {
        logic [WORD_W-1:0] d0;
        logic [WORD_W-1:0] d1;
        logic [WORD_W-1:0] d2;
        logic [WORD_W-1:0] d3;
    } hdr_t;

    // compact first word: selected header dword-0 fields plus low stamp bits
    function automatic logic [WORD_W-1:0] compact_head(input logic [WORD_W-1:0] d0,
                                                       input logic [WORD_W-1:0] stamp);
        return {d0[30:29], d0[28:24], d0[23], d0[19], d0[16], d0[13],
                d0[9:0], stamp[10:0]};
    endfunction

endpackage

// File: rtl/trc_tstamp.sv
module trc_tstamp #(
    parameter int TS_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] stamp
);
    logic [TS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (TS_W >= 32) begin : g_wide
            assign stamp = cnt_q[31:0];
        end else begin : g_narrow
            assign stamp = {{(32-TS_W){1'b0}}, cnt_q};
        end
    endgenerate
endmodule

// File: rtl/trc_pack.sv
module trc_pack
    import trc_pkg::*;
(
    input  trc_pkg::hdr_t           hdr,
    input  logic [WORD_W-1:0]       pfx_word,
    input  logic                    pfx_present,
    input  trc_pkg::layout_e        layout,
    input  logic [WORD_W-1:0]       stamp,
    output trc_pkg::rec_words_t     words,
    output logic [IDX_W-1:0]        last_idx
);
    logic [3:0][WORD_W-1:0] hdr_arr;
    assign hdr_arr = {hdr.d3, hdr.d2, hdr.d1, hdr.d0};

    always_comb begin
        words = '0;
        if (layout == LAYOUT_FULL) begin
            words[0] = FULL_MARK;
            words[1] = pfx_present ? pfx_word : '0;
            for (int i = 0; i < 4; i++) words[2+i] = hdr_arr[i];
            words[6] = '0;
            words[7] = stamp;
            last_idx = IDX_W'(MAX_WRD - 1);
        end else begin
            words[0] = compact_head(hdr.d0, stamp);
            for (int i = 1; i < 4; i++) words[i] = hdr_arr[i];
            last_idx = IDX_W'(3);
        end
    end
endmodule

// File: rtl/trc_emit.sv
module trc_emit
    import trc_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_valid,
    input  trc_pkg::rec_words_t   words_in,
    input  logic [IDX_W-1:0]      last_in,
    output logic [WORD_W-1:0]     out_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  out_last,
    output logic [DROP_W-1:0]     drops
);
    rec_words_t        held_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  end_q;
    logic              busy_q;
    logic [DROP_W-1:0] drop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            end_q  <= '0;
            drop_q <= '0;
        end else begin
            if (busy_q && out_ready) begin
                if (idx_q == end_q) busy_q <= 1'b0;
                else                idx_q  <= idx_q + 1'b1;
            end
            if (cap_valid) begin
                if (busy_q) begin
                    if (drop_q != '1) drop_q <= drop_q + 1'b1;
                end else begin
                    held_q <= words_in;
                    end_q  <= last_in;
                    idx_q  <= '0;
                    busy_q <= 1'b1;
                end
            end
        end
    end

    assign out_data  = held_q[idx_q];
    assign out_valid = busy_q;
    assign out_last  = busy_q && (idx_q == end_q);
    assign drops     = drop_q;
endmodule

// File: rtl/trace_rec_fmt.sv
module trace_rec_fmt
    import trc_pkg::*;
#(
    parameter int TS_W   = 32,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_valid,
    input  logic [31:0]       hdr_dw0,
    input  logic [31:0]       hdr_dw1,
    input  logic [31:0]       hdr_dw2,
    input  logic [31:0]       hdr_dw3,
    input  logic [31:0]       pfx_word,
    input  logic              pfx_present,
    input  logic              fmt_sel,
    output logic [31:0]       rec_data,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic              rec_last,
    output logic [DROP_W-1:0] drop_cnt
);
    logic [31:0]      stamp;
    hdr_t             hdr;
    rec_words_t       words;
    logic [IDX_W-1:0] last_idx;
    layout_e          layout;

    assign hdr    = '{d0: hdr_dw0, d1: hdr_dw1, d2: hdr_dw2, d3: hdr_dw3};
    assign layout = layout_e'(fmt_sel);

    trc_tstamp #(.TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst   (rst),
        .stamp (stamp)
    );

    trc_pack u_pack (
        .hdr         (hdr),
        .pfx_word    (pfx_word),
        .pfx_present (pfx_present),
        .layout      (layout),
        .stamp       (stamp),
        .words       (words),
        .last_idx    (last_idx)
    );

    trc_emit #(.DROP_W(DROP_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .cap_valid (cap_valid),
        .words_in  (words),
        .last_in   (last_idx),
        .out_data  (rec_data),
        .out_valid (rec_valid),
        .out_ready (rec_ready),
        .out_last  (rec_last),
        .drops     (drop_cnt)
    );
endmodule

// File: rtl/trc_fmt_chk.sv
module trc_fmt_chk #(
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cap_valid,
    input logic [31:0]       rec_data,
    input logic              rec_valid,
    input logic              rec_ready,
    input logic              rec_last,
    input logic [DROP_W-1:0] drop_cnt,
    input logic [31:0]       stamp
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!rec_valid && drop_cnt == '0));

    // R7
    stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stamp == $past(stamp) + 32'd1));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_last)));

    // R4
    last_in_rec_chk: assert property (@(posedge clk) disable iff (rst)
        rec_last |-> rec_valid);

    // R9
    drop_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && rec_valid && drop_cnt != '1) |=> (drop_cnt == $past(drop_cnt) + 1'b1));

    // R9
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_valid |=> $stable(drop_cnt));

    // R10
    end_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && rec_valid && rec_ready && rec_last) |=> !rec_valid);
endmodule

bind trace_rec_fmt trc_fmt_chk #(.DROP_W(DROP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cap_valid (cap_valid),
    .rec_data  (rec_data),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_last  (rec_last),
    .drop_cnt  (drop_cnt),
    .stamp     (stamp)
);

// File: tb/test_trace_rec_fmt.sv
`timescale 1ns/1ps
module test_trace_rec_fmt;
    localparam int DW   = 4;
    localparam int DMAX = (1 << DW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_valid = 1'b0;
    logic [31:0] hdr_dw0 = '0, hdr_dw1 = '0, hdr_dw2 = '0, hdr_dw3 = '0;
    logic [31:0] pfx_word = '0;
    logic        pfx_present = 1'b0;
    logic        fmt_sel = 1'b0;
    logic        rec_ready = 1'b1;
    logic [31:0] rec_data;
    logic        rec_valid, rec_last;
    logic [DW-1:0] drop_cnt;

    always #2 clk = ~clk;

    trace_rec_fmt #(.TS_W(32), .DROP_W(DW)) i_trace_rec_fmt (
        .clk(clk), .rst(rst), .cap_valid(cap_valid),
        .hdr_dw0(hdr_dw0), .hdr_dw1(hdr_dw1), .hdr_dw2(hdr_dw2), .hdr_dw3(hdr_dw3),
        .pfx_word(pfx_word), .pfx_present(pfx_present), .fmt_sel(fmt_sel),
        .rec_data(rec_data), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_last(rec_last), .drop_cnt(drop_cnt)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_rec [8];
    int          m_n = 0, m_idx = 0, m_drop = 0;
    bit          m_busy = 0, m_full = 0, stall = 0, started = 0, was_busy;
    int unsigned m_ts = 0;
    logic [31:0] seen_data;

    always @(posedge clk) begin
        started = 1;
        stall = !rst && m_busy && !rec_ready;
        if (rst) begin
            m_busy = 0; m_idx = 0; m_drop = 0; m_ts = 0;
        end else begin
            was_busy = m_busy;
            if (m_busy && rec_ready) begin
                if (m_idx == m_n - 1) m_busy = 0;
                else m_idx++;
            end
            if (cap_valid) begin
                if (was_busy) begin
                    if (m_drop < DMAX) m_drop++;
                end else begin
                    m_full = fmt_sel;
                    m_busy = 1; m_idx = 0;
                    if (fmt_sel) begin
                        m_n = 8;
                        m_rec[0] = 32'hFFFF_FFFF;
                        m_rec[1] = pfx_present ? pfx_word : 32'h0;
                        m_rec[2] = hdr_dw0; m_rec[3] = hdr_dw1;
                        m_rec[4] = hdr_dw2; m_rec[5] = hdr_dw3;
                        m_rec[6] = 32'h0;   m_rec[7] = m_ts;
                    end else begin
                        m_n = 4;
                        m_rec[0] = 32'h0;
                        m_rec[0][31:30] = hdr_dw0[30:29];
                        m_rec[0][29:25] = hdr_dw0[28:24];
                        m_rec[0][24]    = hdr_dw0[23];
                        m_rec[0][23]    = hdr_dw0[19];
                        m_rec[0][22]    = hdr_dw0[16];
                        m_rec[0][21]    = hdr_dw0[13];
                        m_rec[0][20:11] = hdr_dw0[9:0];
                        m_rec[0][10:0]  = m_ts[10:0];
                        m_rec[1] = hdr_dw1; m_rec[2] = hdr_dw2; m_rec[3] = hdr_dw3;
                    end
                end
            end
            m_ts++;
        end
    end

    function automatic string data_tag();
        if (!m_full) return (m_idx == 0) ? "R2" : "R3";
        if (m_idx == 0) return "R5";
        if (m_idx == 1) return "R6";
        if (m_idx == 7) return "R7";
        return "R4";
    endfunction

    always @(negedge clk) begin
        if (started) begin
            check(rst ? "R1 valid" : "R10 valid", {31'b0, rec_valid}, {31'b0, m_busy});
            check("R9 drop", {{(32-DW){1'b0}}, drop_cnt}, 32'(m_drop));
            if (stall) check("R8 hold", rec_data, seen_data);
            if (m_busy && !rst) begin
                check(data_tag(), rec_data, m_rec[m_idx]);
                check("R4 last", {31'b0, rec_last}, {31'b0, m_idx == m_n - 1});
            end
            seen_data = rec_data;
        end
    end

    // header inputs change every cycle
    always @(negedge clk) begin
        hdr_dw0 <= $urandom; hdr_dw1 <= $urandom;
        hdr_dw2 <= $urandom; hdr_dw3 <= $urandom;
        pfx_word <= $urandom;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic full, input logic pfx);
        fmt_sel = full; pfx_present = pfx; cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        rec_ready = 1'b1;
        pulse(1'b0, 1'b0); cyc(6);       // R2 R3 compact
        pulse(1'b1, 1'b1); cyc(10);      // R4 R5 R6 R7 full with prefix
        pulse(1'b1, 1'b0); cyc(10);      // R6 prefix absent
        // R9 R10: strobe held across a compact record and its last handoff
        fmt_sel = 1'b0; cap_valid = 1'b1;
        cyc(9);
        cap_valid = 1'b0; cyc(10);
        // random mix with back-pressure (R8)
        for (int i = 0; i < 1500; i++) begin
            cap_valid   = ($urandom % 10) < 3;
            rec_ready   = ($urandom % 10) < 6;
            fmt_sel     = $urandom % 2;
            pfx_present = $urandom % 2;
            @(negedge clk);
        end
        // long stall drives drop counter into saturation (R9)
        rec_ready = 1'b0; cap_valid = 1'b1; cyc(40);
        cap_valid = 1'b0; rec_ready = 1'b1; cyc(12);
        rst = 1'b1; cyc(2);              // R1 reset again
        rst = 1'b0; cyc(3);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule